// File: doc/BRIEF.md
# Peripheral Clock-Enable Strobe Generator

This block derives single-cycle enable strobes for a set of slow peripherals from one system clock. No clock is divided or gated: each peripheral keeps running on the system clock and acts only in the cycles where its strobe is high. The strobe ratios depend on how the device is clocked. In external-reference mode the system clock is the fixed external input. In PLL mode it is the PLL output, and a different set of ratios applies.

The inputs are a mode bit, an oscillator-standby bit, a 2-bit code that picks the SPI bit-rate divisor, and the 32-bit PLL configuration word. The outputs are strobes for the timer reference, the PWM reference, the SPI reference, the SPI bit clock and the UART. A small read port returns the PLL multiplier field and a flag that marks whether the multiplier is in its legal range. When the flag is low, software is expected to use a configured startup rate in place of the computed one.

Top module: `clk_strobe_gen`

## Requirements
- R1: While rst_n is low, every strobe output, rd_mult and rd_valid are 0.
- R2: One clock after pll_word is applied, rd_mult equals pll_word[31:24]. rd_valid is 1 exactly when that value lies between 10 and 50 inclusive.
- R3: The timer strobe fires once every 144 cycles in PLL mode (ext_mode=0). In external mode (ext_mode=1) it fires every 24 cycles with osc_stby=0 and every 26 cycles with osc_stby=1.
- R4: The PWM strobe fires every 128 cycles in external mode and every 768 cycles in PLL mode.
- R5: The SPI reference strobe fires every 96 cycles in external mode and every 576 cycles in PLL mode.
- R6: The SPI bit strobe fires once per N SPI reference strobes, and always together with one of them. N depends on spi_code: 0 gives 32, 1 gives 8, 2 gives 2 and 3 gives 1. With code 3 the bit strobe equals the reference strobe.
- R7: The UART strobe fires once per 10 internal bus strobes and only together with one. The bus strobe is high in every cycle in external mode. In PLL mode it is high every second cycle when the multiplier is legal and greater than 20, and in every cycle otherwise. The UART period is therefore 10 or 20 cycles.
- R8: Every strobe whose divisor is greater than 1 is high for exactly one cycle per period.
- R9: When a divisor changes, its counter restarts. No strobe appears in the cycle of the change. The first new strobe comes exactly one new period after that cycle, so no period is shortened. A restart of the SPI reference or bus counter also restarts the counter chained to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 = external-reference mode, 0 = PLL mode |
| osc_stby | input | 1 | Oscillator standby; selects the timer ratio in external mode |
| spi_code | input | 2 | SPI bit-rate divisor code |
| pll_word | input | 32 | PLL configuration word; multiplier in bits 31:24 |
| tmr_stb | output | 1 | Timer reference enable strobe |
| pwm_stb | output | 1 | PWM reference enable strobe |
| spi_ref_stb | output | 1 | SPI reference enable strobe |
| spi_bit_stb | output | 1 | SPI bit-clock enable strobe |
| uart_stb | output | 1 | UART enable strobe |
| rd_mult | output | 8 | Registered PLL multiplier |
| rd_valid | output | 1 | Registered multiplier-legal flag |

## Verification
The bench checks multipliers at both edges of the legal range and just outside it. A design with an off-by-one range check would flag 10 or 50 as illegal, or accept 9 or 51. It also checks multipliers on each side of the bus threshold, where a wrong comparison would give a UART period of 10 instead of 20 or the reverse. For the nonlinear SPI code table it measures every code, so any swapped or linear mapping changes a measured period. A timer ratio change is driven mid-count to show that the first new strobe comes a full 26 cycles after the change; a counter that is not restarted, or one that compares against the old divisor, pulses early.

// File: rtl/clk_strobe_pkg.sv
package clk_strobe_pkg;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // nonlinear SPI divisor code table
  function automatic int unsigned spi_code_ratio(input logic [1:0] code);
    case (code)
      2'd0:    return 32;
      2'd1:    return 8;
      2'd2:    return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/strobe_div.sv
module strobe_div #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,       // advance the count this cycle
  input  logic         hold_clr,  // restart forced by an upstream counter
  input  logic [W-1:0] div,       // divisor, 1 or more
  output logic         stb,
  output logic         restart    // brought out for the chained counters and checks
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;
  logic [W-1:0] div_q;
  logic         at_end;

  assign restart = (div != div_q) | hold_clr;
  assign at_end  = (cnt == div_q - ONE);
  assign stb     = adv & at_end & ~restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= ONE;
    end else begin
      div_q <= div;
      if (restart)  cnt <= '0;
      else if (adv) cnt <= at_end ? '0 : cnt + ONE;
    end
  end

  // R8: a divisor above one never gives two strobes in a row
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && div_q > ONE) |=> !stb);

  // R9: the cycle after a restart carries no strobe unless the new divisor is one
  a_r9_no_early_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(restart) && div_q > ONE) |-> !stb);

endmodule

// File: rtl/clk_strobe_gen.sv
module clk_strobe_gen #(
  parameter int unsigned EXT_TMR_RUN    = 24,
  parameter int unsigned EXT_TMR_STBY   = 26,
  parameter int unsigned EXT_PWM        = 128,
  parameter int unsigned EXT_SPI        = 96,
  parameter int unsigned PLL_TMR        = 144,
  parameter int unsigned PLL_PWM        = 768,
  parameter int unsigned PLL_SPI        = 576,
  parameter int unsigned UART_RATIO     = 10,
  parameter int unsigned MULT_LO        = 10,
  parameter int unsigned MULT_HI        = 50,
  parameter int unsigned BUS_MULT_LIMIT = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic        osc_stby,
  input  logic [1:0]  spi_code,
  input  logic [31:0] pll_word,
  output logic        tmr_stb,
  output logic        pwm_stb,
  output logic        spi_ref_stb,
  output logic        spi_bit_stb,
  output logic        uart_stb,
  output logic [7:0]  rd_mult,
  output logic        rd_valid
);
  import clk_strobe_pkg::*;

  localparam int unsigned BIG = max2(max2(max2(EXT_TMR_STBY, EXT_TMR_RUN), max2(EXT_PWM, EXT_SPI)),
                                     max2(max2(PLL_TMR, PLL_PWM), max2(PLL_SPI, max2(UART_RATIO, 32))));
  localparam int unsigned CW    = $clog2(BIG + 1);
  localparam int unsigned NROOT = 4;  // bus, timer, pwm, spi reference
  localparam int unsigned I_BUS = 0;
  localparam int unsigned I_TMR = 1;
  localparam int unsigned I_PWM = 2;
  localparam int unsigned I_SPI = 3;

  function automatic logic mult_legal(input logic [7:0] m);
    return (m >= 8'(MULT_LO)) && (m <= 8'(MULT_HI));
  endfunction

  function automatic logic [CW-1:0] tmr_ratio(input logic ext, input logic stby);
    if (!ext) return CW'(PLL_TMR);
    return stby ? CW'(EXT_TMR_STBY) : CW'(EXT_TMR_RUN);
  endfunction

  logic [7:0]    mult;
  logic          mult_ok;
  logic          bus_half;  // PLL running above the bus threshold
  logic [CW-1:0] root_div  [NROOT];
  logic          root_stb  [NROOT];
  logic          root_rst  [NROOT];
  logic          bit_rst;
  logic          uart_rst;
  logic          bus_stb;

  assign mult     = pll_word[31:24];
  assign mult_ok  = mult_legal(mult);
  assign bus_half = !ext_mode && mult_ok && (mult > 8'(BUS_MULT_LIMIT));

  assign root_div[I_BUS] = bus_half ? CW'(2) : CW'(1);
  assign root_div[I_TMR] = tmr_ratio(ext_mode, osc_stby);
  assign root_div[I_PWM] = ext_mode ? CW'(EXT_PWM) : CW'(PLL_PWM);
  assign root_div[I_SPI] = ext_mode ? CW'(EXT_SPI) : CW'(PLL_SPI);

  for (genvar g = 0; g < NROOT; g++) begin : g_root
    strobe_div #(.W(CW)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (1'b1),
      .hold_clr (1'b0),
      .div      (root_div[g]),
      .stb      (root_stb[g]),
      .restart  (root_rst[g])
    );
  end

  assign bus_stb     = root_stb[I_BUS];
  assign tmr_stb     = root_stb[I_TMR];
  assign pwm_stb     = root_stb[I_PWM];
  assign spi_ref_stb = root_stb[I_SPI];

  strobe_div #(.W(CW)) u_spi_bit (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (root_stb[I_SPI]),
    .hold_clr (root_rst[I_SPI]),
    .div      (CW'(spi_code_ratio(spi_code))),
    .stb      (spi_bit_stb),
    .restart  (bit_rst)
  );

  strobe_div #(.W(CW)) u_uart (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (bus_stb),
    .hold_clr (root_rst[I_BUS]),
    .div      (CW'(UART_RATIO)),
    .stb      (uart_stb),
    .restart  (uart_rst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_mult  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_mult  <= mult;
      rd_valid <= mult_ok;
    end
  end

  // R2: a reported legal flag always comes with an in-range multiplier
  a_r2_valid_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_mult >= 8'(MULT_LO) && rd_mult <= 8'(MULT_HI)));

  // R6: a bit strobe only ever rides on a reference strobe
  a_r6_bit_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    spi_bit_stb |-> spi_ref_stb);

  // R7: the UART strobe only ever rides on a bus strobe
  a_r7_uart_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    uart_stb |-> bus_stb);

  // R7: a settled external mode keeps the bus strobe high in every cycle
  a_r7_ext_bus_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && $past(ext_mode)) |-> bus_stb);

endmodule

// File: tb/sim_clk_strobe_gen.sv
module sim_clk_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_mode, osc_stby;
  logic [1:0]  spi_code;
  logic [31:0] pll_word;
  logic        tmr_stb, pwm_stb, spi_ref_stb, spi_bit_stb, uart_stb;
  logic [7:0]  rd_mult;
  logic        rd_valid;

  int n_chk = 0, n_bad = 0, pushed = 0, popped = 0;
  bit finished = 0;

  typedef struct {int ch; int exp; string tag;} item_t;
  item_t sb_q[$];

  localparam int CH_TMR = 0, CH_PWM = 1, CH_SPI = 2, CH_BIT = 3, CH_UART = 4;

  always #2.5 clk = ~clk;

  clk_strobe_gen u0 (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .osc_stby(osc_stby),
    .spi_code(spi_code), .pll_word(pll_word),
    .tmr_stb(tmr_stb), .pwm_stb(pwm_stb), .spi_ref_stb(spi_ref_stb),
    .spi_bit_stb(spi_bit_stb), .uart_stb(uart_stb),
    .rd_mult(rd_mult), .rd_valid(rd_valid)
  );

  function automatic logic pick(input int ch);
    case (ch)
      CH_TMR:  return tmr_stb;
      CH_PWM:  return pwm_stb;
      CH_SPI:  return spi_ref_stb;
      CH_BIT:  return spi_bit_stb;
      default: return uart_stb;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures the interval between two consecutive strobes on a channel
  initial begin
    forever begin
      item_t it;
      int n;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      do @(negedge clk); while (!pick(it.ch));
      n = 0;
      do begin @(negedge clk); n++; end while (!pick(it.ch));
      chk(n == it.exp, it.tag, n, it.exp);
      popped++;
    end
  end

  task automatic expect_period(input int ch, input int exp, input string tag);
    item_t it;
    it.ch = ch; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic set_cfg(input logic ext, input logic stby, input logic [1:0] code, input logic [7:0] m);
    @(posedge clk); #1;
    ext_mode = ext; osc_stby = stby; spi_code = code; pll_word = {m, 24'h00_5a_c3};
  endtask

  task automatic check_read(input logic [7:0] m, input bit exp_ok, input string tag);
    set_cfg(ext_mode, osc_stby, spi_code, m);
    @(posedge clk); @(negedge clk);
    chk(rd_mult == m, tag, rd_mult, m);
    chk(rd_valid == exp_ok, tag, rd_valid, exp_ok);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int gap;
    rst_n = 1'b0; ext_mode = 1'b1; osc_stby = 1'b0; spi_code = 2'd3; pll_word = {8'd30, 24'h0};
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: everything quiet in reset
    chk({tmr_stb, pwm_stb, spi_ref_stb, spi_bit_stb, uart_stb} == 5'b0, "R1 strobes in reset",
        {tmr_stb, pwm_stb, spi_ref_stb, spi_bit_stb, uart_stb}, 0);
    chk(rd_mult == 8'd0 && rd_valid == 1'b0, "R1 read port in reset", {rd_valid, rd_mult}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2: range edges of the multiplier
    check_read(8'd30, 1'b1, "R2 mult 30");
    check_read(8'd9,  1'b0, "R2 mult 9");
    check_read(8'd10, 1'b1, "R2 mult 10");
    check_read(8'd50, 1'b1, "R2 mult 50");
    check_read(8'd51, 1'b0, "R2 mult 51");

    // external mode ratios
    set_cfg(1'b1, 1'b0, 2'd0, 8'd30);
    expect_period(CH_TMR, 24, "R3 ext timer stby=0");
    expect_period(CH_PWM, 128, "R4 ext pwm");
    expect_period(CH_SPI, 96, "R5 ext spi ref");
    expect_period(CH_BIT, 96 * 32, "R6 spi code 0");
    expect_period(CH_UART, 10, "R7 ext uart");
    set_cfg(1'b1, 1'b0, 2'd1, 8'd30);
    expect_period(CH_BIT, 96 * 8, "R6 spi code 1");
    set_cfg(1'b1, 1'b0, 2'd2, 8'd30);
    expect_period(CH_BIT, 96 * 2, "R6 spi code 2");
    set_cfg(1'b1, 1'b0, 2'd3, 8'd30);
    expect_period(CH_BIT, 96, "R6 spi code 3");
    @(negedge clk);
    chk(spi_bit_stb == spi_ref_stb, "R6 code 3 bit equals ref", spi_bit_stb, spi_ref_stb);
    set_cfg(1'b1, 1'b1, 2'd3, 8'd30);
    expect_period(CH_TMR, 26, "R3 ext timer stby=1");

    // R9: change timer ratio mid-count and time the first new strobe
    set_cfg(1'b1, 1'b0, 2'd3, 8'd30);
    repeat (3) @(posedge clk);
    #1 osc_stby = 1'b1;
    @(negedge clk);
    chk(tmr_stb == 1'b0, "R9 no strobe in change cycle", tmr_stb, 0);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tmr_stb && gap < 200);
    chk(gap == 26, "R9 first strobe after change", gap, 26);

    // PLL mode ratios
    set_cfg(1'b0, 1'b1, 2'd3, 8'd30);
    expect_period(CH_TMR, 144, "R3 pll timer");
    expect_period(CH_PWM, 768, "R4 pll pwm");
    expect_period(CH_SPI, 576, "R5 pll spi ref");
    expect_period(CH_UART, 20, "R7 pll uart mult 30");
    set_cfg(1'b0, 1'b0, 2'd3, 8'd21);
    expect_period(CH_UART, 20, "R7 pll uart mult 21");
    set_cfg(1'b0, 1'b0, 2'd3, 8'd20);
    expect_period(CH_UART, 10, "R7 pll uart mult 20");
    set_cfg(1'b0, 1'b0, 2'd3, 8'd60);
    expect_period(CH_UART, 10, "R7 pll uart illegal mult 60");

    // R8: one-cycle width on the timer strobe
    set_cfg(1'b0, 1'b0, 2'd3, 8'd30);
    do @(negedge clk); while (!tmr_stb);
    @(negedge clk);
    chk(tmr_stb == 1'b0, "R8 timer strobe single cycle", tmr_stb, 0);

    if (!finished) begin
      finished = 1;
      summary();
    end
  end
endmodule